// File: doc/BRIEF.md
# Complex Triple-Product Multiplier

This block multiplies three complex operands, d = a·b·c, in exact fixed-point arithmetic. Every operand part is an 8-bit unsigned word, and each operand has its own binary point. The `a` parts carry 4 fraction bits, the `b` parts carry 5 and the `c` parts carry 6. The first stage forms the complex product a·b and registers it. The second stage multiplies that registered product by `c`, which is delayed by one stage so that it lines up.

Each stage resolves both of its complex cross terms, the real difference and the imaginary sum, in its own carry-save compression tree. A single carry-propagate adder then closes each tree. Subtraction is folded into the tree as inverted partial-product rows plus one constant row, so no separate negation adder is needed.

The two results are signed two's complement words at full precision, with 15 fraction bits. A new operand set can be accepted on every clock. Results leave two cycles later, qualified by a valid strobe.

Top module: `cplx_triple_mul`

## Requirements
- R1: Each input part is 8-bit unsigned. `a` is weighted 2^-4 per LSB, `b` 2^-5 and `c` 2^-6. `d_re` and `d_im` are 27-bit two's complement with LSB weight 2^-15, so 1.0·1.0·1.0 gives d_re = 32768 and d_im = 0.
- R2: `d_re` equals Re(a·b·c) exactly, where ab_re = a_re·b_re − a_im·b_im and ab_im = a_re·b_im + a_im·b_re. This gives d_re = ab_re·c_re − ab_im·c_im.
- R3: `d_im` equals Im(a·b·c) = ab_re·c_im + ab_im·c_re exactly. The internal imaginary part of a·b is never negative.
- R4: A set of operands presented with `in_valid` high at a rising edge produces `out_valid` high, together with its result, after the second following rising edge. Operand sets may arrive on consecutive cycles, and the results keep the order of their operands.
- R5: While the synchronous active-high `rst` is high at a rising edge, `out_valid` is cleared and both outputs are cleared to zero. Any result in flight is discarded.
- R6: Operand values presented with `in_valid` low have no effect. `d_re` and `d_im` hold the last result while `out_valid` is low.
- R7: The operand set a = 184 + j68, b = 92 + j39, c = 78 + j212 gives the exact product. These are 11.5 + j4.23, 2.876 + j1.23 and 1.22 + j3.32, each rounded to nearest in its format.
- R8: The full-scale set, with all six parts equal to 255, gives d_re = −33162750 and d_im = 33162750 without overflow. For every input, bits 26 and 25 of each output are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is present |
| a_re | input | 8 | Real part of a, unsigned, 4 fraction bits |
| a_im | input | 8 | Imaginary part of a, unsigned, 4 fraction bits |
| b_re | input | 8 | Real part of b, unsigned, 5 fraction bits |
| b_im | input | 8 | Imaginary part of b, unsigned, 5 fraction bits |
| c_re | input | 8 | Real part of c, unsigned, 6 fraction bits |
| c_im | input | 8 | Imaginary part of c, unsigned, 6 fraction bits |
| out_valid | output | 1 | Result is present |
| d_re | output | 27 | Real part of d, signed, 15 fraction bits |
| d_im | output | 27 | Imaginary part of d, signed, 15 fraction bits |

## Verification
Unit operands check where the binary point of the result lands. The rounded reference vector mixes fractional bits in all six parts, so a swapped cross term or a wrong sign shows up there. The full-scale set drives the largest magnitudes and a negative real part, which exercises the constant correction row and the top output bits. Long back-to-back random streams, interleaved with idle gaps that carry garbage operands, separate throughput and ordering faults from faults where the outputs are disturbed while no result is valid.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

  // Rows left after lvl layers of 3:2 compression, starting from n rows
  function automatic int rows_after(input int n, input int lvl);
    int r;
    r = n;
    for (int k = 0; k < lvl; k++) r = (r / 3) * 2 + (r % 3);
    return r;
  endfunction

  // Layers needed to bring n rows down to two
  function automatic int tree_levels(input int n);
    int r;
    int l;
    r = n;
    l = 0;
    while (r > 2) begin
      r = (r / 3) * 2 + (r % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/cplx_csa_tree.sv
module cplx_csa_tree #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic [W-1:0] rows [N],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  localparam int LV = cplx_pkg::tree_levels(N);

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int NI = cplx_pkg::rows_after(N, lv);
    localparam int NG = NI / 3;
    localparam int NR = NI % 3;
    localparam int NO = 2 * NG + NR;

    logic [W-1:0] cur [NI];
    logic [W-1:0] nxt [NO];

    if (lv == 0) begin : g_src
      for (genvar k = 0; k < NI; k++) begin : g_cp
        assign cur[k] = rows[k];
      end
    end else begin : g_src
      for (genvar k = 0; k < NI; k++) begin : g_cp
        assign cur[k] = g_lvl[lv-1].nxt[k];
      end
    end

    // full-adder layer: three rows in, sum row and shifted carry row out
    for (genvar g = 0; g < NG; g++) begin : g_fa
      assign nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
      assign nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) |
                           (cur[3*g] & cur[3*g+2]) |
                           (cur[3*g+1] & cur[3*g+2])) << 1;
    end

    for (genvar r = 0; r < NR; r++) begin : g_pass
      assign nxt[2*NG+r] = cur[3*NG+r];
    end
  end

  assign sum_o   = g_lvl[LV-1].nxt[0];
  assign carry_o = g_lvl[LV-1].nxt[1];

endmodule

// File: rtl/cplx_mixed_dot.sv
// x0*y0 + x1*y1, or x0*y0 - x1*y1 when SUB, with signed x and unsigned y.
// All partial products meet in one compression tree and one final adder.
module cplx_mixed_dot #(
  parameter int XW  = 9,
  parameter int YW  = 8,
  parameter int OW  = 18,
  parameter bit SUB = 1'b0
) (
  input  logic signed [XW-1:0] x0,
  input  logic        [YW-1:0] y0,
  input  logic signed [XW-1:0] x1,
  input  logic        [YW-1:0] y1,
  output logic signed [OW-1:0] dot_o
);

  localparam int NROW = 2 * YW + 1;

  logic [OW-1:0] x0_ext;
  logic [OW-1:0] x1_ext;
  logic [OW-1:0] rows [NROW];
  logic [OW-1:0] tree_sum;
  logic [OW-1:0] tree_carry;

  assign x0_ext = OW'(x0);
  assign x1_ext = OW'(x1);

  for (genvar j = 0; j < YW; j++) begin : g_pp
    assign rows[j] = y0[j] ? (x0_ext << j) : '0;
    if (SUB) begin : g_neg
      // -(row) = ~row + 1; the +1 of every row sits in the constant row
      assign rows[YW+j] = ~(y1[j] ? (x1_ext << j) : OW'(0));
    end else begin : g_pos
      assign rows[YW+j] = y1[j] ? (x1_ext << j) : '0;
    end
  end

  assign rows[2*YW] = SUB ? OW'(YW) : '0;

  cplx_csa_tree #(.W(OW), .N(NROW)) u_tree (
    .rows   (rows),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  assign dot_o = $signed(tree_sum + tree_carry);

endmodule

// File: rtl/cplx_triple_mul.sv
module cplx_triple_mul #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int C_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [A_W-1:0]               a_re,
  input  logic [A_W-1:0]               a_im,
  input  logic [B_W-1:0]               b_re,
  input  logic [B_W-1:0]               b_im,
  input  logic [C_W-1:0]               c_re,
  input  logic [C_W-1:0]               c_im,
  output logic                         out_valid,
  output logic signed [A_W+B_W+C_W+2:0] d_re,
  output logic signed [A_W+B_W+C_W+2:0] d_im
);

  localparam int P_W = A_W + B_W + 2;
  localparam int D_W = P_W + C_W + 1;

  logic signed [A_W:0]   a_re_s;
  logic signed [A_W:0]   a_im_s;
  logic signed [P_W-1:0] ab_sum [2];
  logic signed [P_W-1:0] p_q    [2];
  logic        [C_W-1:0] c_re_q;
  logic        [C_W-1:0] c_im_q;
  logic                  v1_q;
  logic signed [D_W-1:0] abc_sum [2];
  logic signed [D_W-1:0] d_q     [2];
  logic                  v2_q;

  assign a_re_s = $signed({1'b0, a_re});
  assign a_im_s = $signed({1'b0, a_im});

  // stage 1: index 0 real (difference), index 1 imaginary (sum)
  for (genvar pt = 0; pt < 2; pt++) begin : g_ab
    cplx_mixed_dot #(.XW(A_W+1), .YW(B_W), .OW(P_W), .SUB(pt == 0)) u_dot (
      .x0   (a_re_s),
      .y0   ((pt == 0) ? b_re : b_im),
      .x1   (a_im_s),
      .y1   ((pt == 0) ? b_im : b_re),
      .dot_o(ab_sum[pt])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      p_q[0] <= '0;
      p_q[1] <= '0;
      c_re_q <= '0;
      c_im_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        p_q[0] <= ab_sum[0];
        p_q[1] <= ab_sum[1];
        c_re_q <= c_re;
        c_im_q <= c_im;
      end
    end
  end

  // stage 2: (p_re + j p_im) * (c_re + j c_im)
  for (genvar pt = 0; pt < 2; pt++) begin : g_abc
    cplx_mixed_dot #(.XW(P_W), .YW(C_W), .OW(D_W), .SUB(pt == 0)) u_dot (
      .x0   (p_q[0]),
      .y0   ((pt == 0) ? c_re_q : c_im_q),
      .x1   (p_q[1]),
      .y1   ((pt == 0) ? c_im_q : c_re_q),
      .dot_o(abc_sum[pt])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q   <= 1'b0;
      d_q[0] <= '0;
      d_q[1] <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        d_q[0] <= abc_sum[0];
        d_q[1] <= abc_sum[1];
      end
    end
  end

  assign out_valid = v2_q;
  assign d_re      = d_q[0];
  assign d_im      = d_q[1];

endmodule

// File: rtl/cplx_triple_mul_chk.sv
module cplx_triple_mul_chk #(
  parameter int P_W = 18,
  parameter int D_W = 27
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic signed [D_W-1:0] d_re,
  input logic signed [D_W-1:0] d_im,
  input logic                  v1,
  input logic signed [P_W-1:0] ab_im
);

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_no_result_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> (!out_valid && d_re == '0 && d_im == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(d_re) && $stable(d_im)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (d_re[D_W-1] == d_re[D_W-2] && d_im[D_W-1] == d_im[D_W-2]));

  p_ab_imag_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    v1 |-> !ab_im[P_W-1]);

endmodule

bind cplx_triple_mul cplx_triple_mul_chk #(.P_W(P_W), .D_W(D_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .d_re     (d_re),
  .d_im     (d_im),
  .v1       (v1_q),
  .ab_im    (p_q[1])
);

// File: tb/cplx_triple_mul_tb_top.sv
`timescale 1ns/1ps
module cplx_triple_mul_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, c_re = '0, c_im = '0;
  logic out_valid;
  logic signed [26:0] d_re, d_im;

  always #2.5 clk = ~clk;

  cplx_triple_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .c_re(c_re), .c_im(c_im),
    .out_valid(out_valid), .d_re(d_re), .d_im(d_im)
  );

  typedef struct {
    longint re;
    longint im;
    longint due;
    string  tag;
  } exp_t;

  exp_t   sb_q[$];
  longint cyc = 0;
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done = 1'b0;
  longint last_re = 0;
  longint last_im = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: apply one operand set and push its expected result
  task automatic push_op(input logic [7:0] ar, ai, br, bi, cr, ci, input string tag);
    exp_t   e;
    longint pr, pi;
    @(negedge clk);
    a_re = ar; a_im = ai; b_re = br; b_im = bi; c_re = cr; c_im = ci;
    in_valid = 1'b1;
    pr = longint'(ar) * br - longint'(ai) * bi;
    pi = longint'(ar) * bi + longint'(ai) * br;
    e.re  = pr * cr - pi * ci;
    e.im  = pr * ci + pi * cr;
    e.due = cyc + 2;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // idle cycles with garbage operands (R6)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_re = 8'($urandom); a_im = 8'($urandom); b_re = 8'($urandom);
      b_im = 8'($urandom); c_re = 8'($urandom); c_im = 8'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R4", "unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.due, "R4", "result cycle", cyc, e.due);
          check(longint'(d_re) == e.re, {e.tag, " R2"}, "d_re", longint'(d_re), e.re);
          check(longint'(d_im) == e.im, {e.tag, " R3"}, "d_im", longint'(d_im), e.im);
          last_re = e.re;
          last_im = e.im;
        end
      end else begin
        check(longint'(d_re) == last_re && longint'(d_im) == last_im, "R6",
              "hold d_re", longint'(d_re), last_re);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R5: reset state
    check(out_valid == 1'b0, "R5", "out_valid in reset", out_valid, 0);
    check(d_re == 0 && d_im == 0, "R5", "d_re in reset", longint'(d_re), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1: 1.0 * 1.0 * 1.0 and binary point placement
    push_op(8'd16, 8'd0, 8'd32, 8'd0, 8'd64, 8'd0, "R1");
    idle(3);
    check(last_re == 32768, "R1", "unit product weight", last_re, 32768);

    // R7: rounded reference vector
    push_op(8'd184, 8'd68, 8'd92, 8'd39, 8'd78, 8'd212, "R7");
    idle(3);

    // R8: full scale, then zero operands
    push_op(8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, "R8");
    idle(3);
    check(last_re == -64'sd33162750 && last_im == 64'sd33162750, "R8",
          "full-scale d_re", last_re, -64'sd33162750);
    push_op(8'd0, 8'd0, 8'd200, 8'd17, 8'd255, 8'd3, "R8");
    push_op(8'd255, 8'd0, 8'd0, 8'd255, 8'd0, 8'd255, "R8");
    idle(3);

    // R4/R2/R3: back-to-back random stream
    for (int i = 0; i < 300; i++)
      push_op(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), "R4");
    idle(4);

    // R6: random stream with gaps of garbage operands
    for (int i = 0; i < 200; i++) begin
      push_op(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), "R6");
      idle(int'($urandom_range(0, 3)));
    end
    idle(4);

    // R5: reset with a result in flight discards it
    push_op(8'd100, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90, "R5");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sb_q.delete();
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid after reset", out_valid, 0);
    check(d_re == 0 && d_im == 0, "R5", "d_im after reset", longint'(d_im), 0);
    last_re = 0;
    last_im = 0;
    rst = 1'b0;
    idle(4);
    push_op(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, "R5");
    idle(4);

    check(sb_q.size() == 0, "R4", "results left pending", sb_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule